// File: doc/BRIEF.md
# Streaming Direct-Mapped Instruction Cache

This block is a read-only instruction cache placed between a 32-bit fetch port and a burst-capable memory read port. It holds 4 Kbytes of instruction words in 256 lines of four 32-bit words. The lines are direct-mapped, and each line has a physical tag and one presence bit per word. A fetch that hits returns its word one cycle later and does not stall. A fetch that misses starts a refill burst. The burst is 1, 2 or 4 words long, chosen at run time by `burst_sel`.

During a refill the cache streams: the word the core asked for is handed over in the cycle after it arrives from memory, even if the burst has more words to come. A short burst marks only the words it fetched as present, so later fetches to the other words of that line miss and refill only their own part. The core holds `fetch_req` and `fetch_addr` steady while `fetch_wait` is high.

A one-cycle pulse on `inval_req` starts a global invalidate. The invalidate clears one line per cycle and blocks all fetches until it completes. If a refill is in flight when the request arrives, the invalidate waits until that refill has finished.

Top module: `icache_stream`

## Requirements
- R1: After reset, no word is present, `fetch_valid`, `mem_req` and `inval_busy` are low, and the first fetch of any address misses.
- R2: A fetch to a present word is taken in the cycle it is presented, with `fetch_wait` low. `fetch_valid` is high with the word on `fetch_data` in the next cycle, and no memory request is made.
- R3: On a miss, `mem_req` stays high, with `mem_addr` and `mem_len` stable, until the cycle in which `mem_ack` is high. `mem_len` in words is given by `burst_sel`: 00 gives 1, 01 gives 2, and 10 or 11 give 4.
- R4: `mem_addr` carries the fetch tag in bits 31:12 and the index in bits 11:4. Bits 3:2 hold the start word, which is the requested word (fetch_addr bits 3:2) rounded down to a multiple of the burst length. Bits 1:0 are zero. One word is taken per `mem_rvalid` cycle, in ascending word order.
- R5: A waiting fetch whose word is part of the active refill completes in the cycle after that word's `mem_rvalid` cycle, carrying `mem_rdata`, without waiting for the rest of the burst.
- R6: After a short burst only the fetched words hit. A fetch to another word of the same line misses and refills only its own burst. Words fetched earlier with the same tag stay present.
- R7: A miss whose tag differs from the one stored at its index discards every word of the old line.
- R8: An invalidate request taken while no refill is active keeps `inval_busy` high for exactly 256 cycles after the request edge. After that, every word fetched earlier misses.
- R9: While `inval_busy` is high, a presented fetch is not taken (`fetch_wait` high).
- R10: When an invalidate request and a fetch to a present word arrive in the same cycle, the invalidate wins. The fetch waits through the whole clear and is then served by a new refill.
- R11: An invalidate request that arrives during a refill is held until the refill's last word has arrived. `inval_busy` is high from the request onward, and the waiting fetch is served by a new refill after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_sel | input | 2 | Refill length select, sampled at the miss |
| inval_req | input | 1 | One-cycle global invalidate request |
| inval_busy | output | 1 | Invalidate pending or in progress |
| fetch_req | input | 1 | Fetch request, held until taken |
| fetch_addr | input | 32 | Physical byte address of the fetch |
| fetch_wait | output | 1 | Fetch presented but not taken this cycle |
| fetch_valid | output | 1 | Fetched word valid |
| fetch_data | output | 32 | Fetched instruction word |
| mem_req | output | 1 | Refill burst request |
| mem_addr | output | 32 | Byte address of the burst's first word |
| mem_len | output | 3 | Burst length in words |
| mem_ack | input | 1 | Memory accepts the burst request |
| mem_rvalid | input | 1 | One refill word on mem_rdata |
| mem_rdata | input | 32 | Refill data word |

## Verification
Two situations bring two functions into the same cycle. In the first, the array write of an arriving refill word coincides with the forwarding of that same word to a stalled fetch. The bench fetches the third word of a line with zero memory latency and requires completion exactly four cycles after the fetch is presented, with the memory word's value. In the second, an invalidate request meets a fetch to a present word in one cycle. The bench drives both together and requires that the fetch stalls for more than the 256-cycle clear and then causes exactly one new memory request. A third overlap places an invalidate in the middle of a refill, and the bench checks that two bursts are issued in total.

// File: rtl/icache_pkg.sv
package icache_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_REQ,
      SEQ_FILL,
      SEQ_CLEAR
   } seq_state_e;

   // Refill length in words for a burst_sel code: 00 -> 1, 01 -> 2, 1x -> 4.
   function automatic logic [2:0] burst_words(input logic [1:0] sel);
      case (sel)
         2'b00:   burst_words = 3'd1;
         2'b01:   burst_words = 3'd2;
         default: burst_words = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
   parameter int unsigned LINES      = 256,
   parameter int unsigned LINE_WORDS = 4,
   parameter int unsigned TAG_W      = 20,
   localparam int unsigned IDX_W     = $clog2(LINES),
   localparam int unsigned OFF_W     = $clog2(LINE_WORDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [TAG_W-1:0]      rd_tag,
   output logic [LINE_WORDS-1:0] rd_present,
   input  logic                  alloc_en,
   input  logic [IDX_W-1:0]      alloc_idx,
   input  logic [TAG_W-1:0]      alloc_tag,
   input  logic                  alloc_drop,
   input  logic                  mark_en,
   input  logic [IDX_W-1:0]      mark_idx,
   input  logic [OFF_W-1:0]      mark_word,
   input  logic                  wipe_en,
   input  logic [IDX_W-1:0]      wipe_idx
);

   logic [TAG_W-1:0]      tag_q     [LINES];
   logic [LINE_WORDS-1:0] present_q [LINES];

   assign rd_tag     = tag_q[rd_idx];
   assign rd_present = present_q[rd_idx];

   always_ff @(posedge clk) begin
      if (alloc_en) begin
         tag_q[alloc_idx] <= alloc_tag;
      end
   end

   // Allocation, word marking and wiping never fall in the same cycle:
   // each belongs to a different sequencer state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            present_q[i] <= '0;
         end
      end else begin
         if (wipe_en) begin
            present_q[wipe_idx] <= '0;
         end
         if (alloc_en && alloc_drop) begin
            present_q[alloc_idx] <= '0;
         end
         if (mark_en) begin
            present_q[mark_idx][mark_word] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] word_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         word_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/icache_refill_seq.sv
module icache_refill_seq
   import icache_pkg::*;
#(
   parameter int unsigned LINES      = 256,
   parameter int unsigned LINE_WORDS = 4,
   parameter int unsigned TAG_W      = 20,
   parameter int unsigned BYTE_OFF   = 2,
   localparam int unsigned IDX_W     = $clog2(LINES),
   localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
   localparam int unsigned LEN_W     = OFF_W + 1,
   localparam int unsigned ADDR_W    = TAG_W + IDX_W + OFF_W + BYTE_OFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_go,
   input  logic [TAG_W-1:0]  miss_tag,
   input  logic [IDX_W-1:0]  miss_idx,
   input  logic [OFF_W-1:0]  miss_word,
   input  logic [1:0]        burst_sel,
   input  logic              inval_req,
   output logic              seq_idle,
   output logic              seq_block,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LEN_W-1:0]  mem_len,
   input  logic              mem_ack,
   input  logic              mem_rvalid,
   output logic              fill_we,
   output logic [TAG_W-1:0]  fill_tag,
   output logic [IDX_W-1:0]  fill_idx,
   output logic [OFF_W-1:0]  fill_word,
   output logic              wipe_en,
   output logic [IDX_W-1:0]  wipe_idx
);

   seq_state_e       state_q;
   logic [TAG_W-1:0] tag_q;
   logic [IDX_W-1:0] idx_q;
   logic [OFF_W-1:0] word_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] left_q;
   logic             inval_pend_q;
   logic [IDX_W-1:0] wipe_q;

   logic [LEN_W-1:0] new_len;
   logic [OFF_W-1:0] len_mask;
   logic [OFF_W-1:0] start_word;

   assign new_len    = LEN_W'(burst_words(burst_sel));
   assign len_mask   = OFF_W'(new_len - LEN_W'(1));
   assign start_word = miss_word & ~len_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SEQ_IDLE;
         tag_q        <= '0;
         idx_q        <= '0;
         word_q       <= '0;
         len_q        <= '0;
         left_q       <= '0;
         inval_pend_q <= 1'b0;
         wipe_q       <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (inval_req || inval_pend_q) begin
                  state_q      <= SEQ_CLEAR;
                  wipe_q       <= '0;
                  inval_pend_q <= 1'b0;
               end else if (miss_go) begin
                  state_q <= SEQ_REQ;
                  tag_q   <= miss_tag;
                  idx_q   <= miss_idx;
                  word_q  <= start_word;
                  len_q   <= new_len;
                  left_q  <= new_len;
               end
            end
            SEQ_REQ: begin
               if (inval_req) inval_pend_q <= 1'b1;
               if (mem_ack) state_q <= SEQ_FILL;
            end
            SEQ_FILL: begin
               if (inval_req) inval_pend_q <= 1'b1;
               if (mem_rvalid) begin
                  word_q <= word_q + OFF_W'(1);
                  left_q <= left_q - LEN_W'(1);
                  if (left_q == LEN_W'(1)) state_q <= SEQ_IDLE;
               end
            end
            default: begin
               wipe_q <= wipe_q + IDX_W'(1);
               if (wipe_q == IDX_W'(LINES - 1)) state_q <= SEQ_IDLE;
            end
         endcase
      end
   end

   assign seq_idle  = (state_q == SEQ_IDLE);
   assign seq_block = inval_req || inval_pend_q || (state_q == SEQ_CLEAR);
   assign mem_req   = (state_q == SEQ_REQ);
   assign mem_addr  = {tag_q, idx_q, word_q, {BYTE_OFF{1'b0}}};
   assign mem_len   = len_q;
   assign fill_we   = (state_q == SEQ_FILL) && mem_rvalid;
   assign fill_tag  = tag_q;
   assign fill_idx  = idx_q;
   assign fill_word = word_q;
   assign wipe_en   = (state_q == SEQ_CLEAR);
   assign wipe_idx  = wipe_q;

endmodule

// File: rtl/icache_stream.sv
module icache_stream #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned LINES      = 256,
   parameter int unsigned LINE_WORDS = 4,
   parameter bit          STREAM_EN  = 1'b1,
   localparam int unsigned BYTE_OFF  = $clog2(DATA_W / 8),
   localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
   localparam int unsigned IDX_W     = $clog2(LINES),
   localparam int unsigned TAG_W     = ADDR_W - IDX_W - OFF_W - BYTE_OFF,
   localparam int unsigned LEN_W     = OFF_W + 1,
   localparam int unsigned DEPTH     = LINES * LINE_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        burst_sel,
   input  logic              inval_req,
   output logic              inval_busy,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_wait,
   output logic              fetch_valid,
   output logic [DATA_W-1:0] fetch_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LEN_W-1:0]  mem_len,
   input  logic              mem_ack,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);

   if (LINE_WORDS != 4) begin : g_bad_line
      $error("icache_stream: burst codes need exactly four words per line");
   end
   if ((1 << IDX_W) != LINES) begin : g_bad_lines
      $error("icache_stream: LINES must be a power of two");
   end
   if ((DATA_W % 8) != 0 || (1 << BYTE_OFF) * 8 != DATA_W) begin : g_bad_data
      $error("icache_stream: DATA_W must be a power-of-two byte count");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("icache_stream: address too narrow for the geometry");
   end

   logic [TAG_W-1:0] f_tag;
   logic [IDX_W-1:0] f_idx;
   logic [OFF_W-1:0] f_word;
   logic [BYTE_OFF-1:0] unused_byte_bits;

   assign f_tag            = fetch_addr[ADDR_W-1 -: TAG_W];
   assign f_idx            = fetch_addr[BYTE_OFF+OFF_W +: IDX_W];
   assign f_word           = fetch_addr[BYTE_OFF +: OFF_W];
   assign unused_byte_bits = fetch_addr[BYTE_OFF-1:0];

   logic [TAG_W-1:0]      rd_tag;
   logic [LINE_WORDS-1:0] rd_present;
   logic [DATA_W-1:0]     rd_data;
   logic                  seq_idle, seq_block;
   logic                  fill_we;
   logic [TAG_W-1:0]      fill_tag;
   logic [IDX_W-1:0]      fill_idx;
   logic [OFF_W-1:0]      fill_word;
   logic                  wipe_en;
   logic [IDX_W-1:0]      wipe_idx;
   logic                  hit, fwd, accept, miss_go;

   assign hit     = rd_present[f_word] && (rd_tag == f_tag);
   assign accept  = fetch_req && !seq_block && (hit || fwd);
   assign miss_go = fetch_req && seq_idle && !seq_block && !hit;

   if (STREAM_EN) begin : g_stream
      assign fwd = fill_we && (fill_idx == f_idx) && (fill_tag == f_tag)
                   && (fill_word == f_word);
   end else begin : g_no_stream
      assign fwd = 1'b0;
   end

   icache_tag_store #(
      .LINES(LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)
   ) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (f_idx),
      .rd_tag     (rd_tag),
      .rd_present (rd_present),
      .alloc_en   (miss_go),
      .alloc_idx  (f_idx),
      .alloc_tag  (f_tag),
      .alloc_drop (rd_tag != f_tag),
      .mark_en    (fill_we),
      .mark_idx   (fill_idx),
      .mark_word  (fill_word),
      .wipe_en    (wipe_en),
      .wipe_idx   (wipe_idx)
   );

   icache_data_store #(
      .DEPTH(DEPTH), .DATA_W(DATA_W)
   ) u_data (
      .clk     (clk),
      .wr_en   (fill_we),
      .wr_addr ({fill_idx, fill_word}),
      .wr_data (mem_rdata),
      .rd_addr ({f_idx, f_word}),
      .rd_data (rd_data)
   );

   icache_refill_seq #(
      .LINES(LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .BYTE_OFF(BYTE_OFF)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_go    (miss_go),
      .miss_tag   (f_tag),
      .miss_idx   (f_idx),
      .miss_word  (f_word),
      .burst_sel  (burst_sel),
      .inval_req  (inval_req),
      .seq_idle   (seq_idle),
      .seq_block  (seq_block),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_len    (mem_len),
      .mem_ack    (mem_ack),
      .mem_rvalid (mem_rvalid),
      .fill_we    (fill_we),
      .fill_tag   (fill_tag),
      .fill_idx   (fill_idx),
      .fill_word  (fill_word),
      .wipe_en    (wipe_en),
      .wipe_idx   (wipe_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_valid <= 1'b0;
         fetch_data  <= '0;
      end else begin
         fetch_valid <= accept;
         if (accept) begin
            fetch_data <= fwd ? mem_rdata : rd_data;
         end
      end
   end

   assign fetch_wait = fetch_req && !accept;
   assign inval_busy = seq_block;

endmodule

// File: rtl/icache_stream_chk.sv
module icache_stream_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic              fetch_wait,
   input logic              fetch_valid,
   input logic              inval_busy,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [LEN_W-1:0]  mem_len,
   input logic              mem_ack
);

   // R2: a taken fetch delivers its word in the following cycle
   a_r2_taken_gives_word: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_wait) |=> fetch_valid);

   // R2: no word appears without a taken fetch one cycle before
   a_r2_word_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_req && !fetch_wait) |=> !fetch_valid);

   // R3: an unaccepted request stays up with a steady address and length
   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

   // R3: only the three legal burst lengths are requested
   a_r3_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_len == LEN_W'(1) || mem_len == LEN_W'(2) || mem_len == LEN_W'(4)));

   // R4: the burst start is word aligned and a multiple of its length
   a_r4_start_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00
                   && (mem_len != LEN_W'(2) || !mem_addr[2])
                   && (mem_len != LEN_W'(4) || mem_addr[3:2] == 2'b00)));

   // R9: nothing is taken while an invalidate is pending or running
   a_r9_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (inval_busy && fetch_req) |-> fetch_wait);

endmodule

bind icache_stream icache_stream_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_req   (fetch_req),
   .fetch_wait  (fetch_wait),
   .fetch_valid (fetch_valid),
   .inval_busy  (inval_busy),
   .mem_req     (mem_req),
   .mem_addr    (mem_addr),
   .mem_len     (mem_len),
   .mem_ack     (mem_ack)
);

// File: tb/icache_stream_bench.sv
module icache_stream_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  burst_sel;
   logic        inval_req;
   logic        inval_busy;
   logic        fetch_req;
   logic [31:0] fetch_addr;
   logic        fetch_wait;
   logic        fetch_valid;
   logic [31:0] fetch_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [2:0]  mem_len;
   logic        mem_ack;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;

   always #10 clk = ~clk;

   icache_stream u_icache_stream (
      .clk(clk), .rst_n(rst_n), .burst_sel(burst_sel), .inval_req(inval_req),
      .inval_busy(inval_busy), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_wait(fetch_wait), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_ack(mem_ack),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int          n_checks = 0;
   int          n_fails  = 0;
   bit          reported = 1'b0;
   logic [31:0] exp_q[$];
   int          req_count = 0;
   logic [31:0] last_addr = '0;
   int          last_len = 0;
   int          ack_delay = 0;
   int          data_delay = 0;
   int          bg_waits = 0;

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[7:0], a[31:8]} ^ 32'h9E37_79B9;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      end
   endtask

   // Driver: called right after a falling edge; returns right after one.
   task automatic fetch(input logic [31:0] a, output int waits);
      fetch_req  = 1'b1;
      fetch_addr = a;
      exp_q.push_back(mem_word({a[31:2], 2'b00}));
      #1;
      waits = 0;
      while (fetch_wait) begin
         @(negedge clk);
         #1;
         waits++;
      end
      @(negedge clk);
      fetch_req = 1'b0;
   endtask

   // Monitor: scoreboard on delivered words (R2, R5)
   always @(negedge clk) begin
      if (rst_n && fetch_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2", "word with nothing expected", fetch_data, 32'h0);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(fetch_data == e, "R2", "delivered word", fetch_data, e);
         end
      end
   end

   // Memory model: drives at falling edges
   initial begin
      mem_ack    = 1'b0;
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      forever begin
         @(negedge clk);
         if (rst_n && mem_req) begin
            logic [31:0] a0;
            a0 = mem_addr;
            for (int d = 0; d < ack_delay; d++) begin
               @(negedge clk);
               check(mem_req && mem_addr == a0, "R3", "request held until ack",
                     mem_addr, a0);
            end
            mem_ack   = 1'b1;
            req_count++;
            last_addr = mem_addr;
            last_len  = int'(mem_len);
            @(negedge clk);
            mem_ack = 1'b0;
            repeat (data_delay) @(negedge clk);
            for (int w = 0; w < last_len; w++) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem_word(last_addr + 32'(4 * w));
               @(negedge clk);
            end
            mem_rvalid = 1'b0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "WATCHDOG", "run did not end", 32'h0, 32'h1);
      report();
      $finish;
   end

   initial begin
      int w;
      int rc;
      logic [31:0] ra, rb, rcl, rd, re, rf;
      rst_n      = 1'b0;
      burst_sel  = 2'b10;
      inval_req  = 1'b0;
      fetch_req  = 1'b0;
      fetch_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!fetch_valid, "R1", "fetch_valid after reset", 32'(fetch_valid), 0);
      check(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 0);
      check(!inval_busy, "R1", "inval_busy after reset", 32'(inval_busy), 0);

      // R1, R3: first fetch misses, four-word burst, delayed ack
      ra = 32'h0001_2340;
      ack_delay = 2; data_delay = 1; burst_sel = 2'b10;
      fetch(ra, w);
      check(req_count == 1, "R1", "first fetch misses", 32'(req_count), 1);
      check(last_addr == ra, "R4", "burst start address", last_addr, ra);
      check(last_len == 4, "R3", "burst length code 10", 32'(last_len), 4);

      // R2: the rest of the line hits with no stall
      repeat (4) @(negedge clk);
      for (int k = 1; k < 4; k++) begin
         fetch(ra + 32'(4 * k), w);
         check(w == 0, "R2", "hit stall cycles", 32'(w), 0);
      end
      check(req_count == 1, "R2", "no request on hits", 32'(req_count), 1);

      // R5: third word of a line streamed the cycle after its arrival
      ack_delay = 0; data_delay = 0;
      rb = 32'h0004_5678;
      fetch(rb, w);
      check(w == 4, "R5", "streamed word stall cycles", 32'(w), 4);
      check(last_addr == 32'h0004_5670, "R4", "line-aligned start", last_addr, 32'h0004_5670);
      repeat (4) @(negedge clk);

      // R4, R6: two-word bursts
      burst_sel = 2'b01;
      rcl = 32'h0007_89AC;
      fetch(rcl, w);
      check(last_addr == 32'h0007_89A8, "R4", "start rounded to pair", last_addr, 32'h0007_89A8);
      check(last_len == 2, "R3", "burst length code 01", 32'(last_len), 2);
      check(w == 3, "R5", "second word of pair stall", 32'(w), 3);
      repeat (2) @(negedge clk);
      fetch(rcl - 32'd4, w);
      check(w == 0, "R6", "fetched partner word hits", 32'(w), 0);
      rc = req_count;
      fetch(rcl - 32'd12, w);
      check(req_count == rc + 1, "R6", "unfetched word misses", 32'(req_count), 32'(rc + 1));
      check(last_addr == 32'h0007_89A0, "R6", "refill of own pair only", last_addr, 32'h0007_89A0);
      repeat (2) @(negedge clk);
      fetch(rcl - 32'd8, w);
      check(w == 0, "R6", "new pair partner hits", 32'(w), 0);
      fetch(rcl - 32'd4, w);
      check(w == 0, "R6", "earlier pair still present", 32'(w), 0);

      // R3, R6: single-word bursts
      burst_sel = 2'b00;
      rd = 32'h0009_0004;
      fetch(rd, w);
      check(last_len == 1 && last_addr == rd, "R3", "single word burst", last_addr, rd);
      check(w == 2, "R5", "single word stall", 32'(w), 2);
      rc = req_count;
      fetch(rd + 32'd4, w);
      check(req_count == rc + 1, "R6", "neighbour of single word misses", 32'(req_count), 32'(rc + 1));

      // R7: conflicting tag at the same index discards the old line
      re = rd + 32'h0000_1000;
      fetch(re, w);
      fetch(re, w);
      check(w == 0, "R7", "new tag word hits", 32'(w), 0);
      rc = req_count;
      fetch(rd, w);
      check(req_count == rc + 1, "R7", "old tag word misses", 32'(req_count), 32'(rc + 1));

      // R8: invalidate takes 256 cycles, then earlier words miss
      @(negedge clk);
      inval_req = 1'b1;
      @(negedge clk);
      inval_req = 1'b0;
      w = 0;
      while (inval_busy && w < 1000) begin
         w++;
         @(negedge clk);
      end
      check(w == 256, "R8", "clear duration", 32'(w), 256);
      rc = req_count;
      fetch(ra + 32'd4, w);
      check(req_count == rc + 1, "R8", "word misses after clear", 32'(req_count), 32'(rc + 1));
      repeat (2) @(negedge clk);
      fetch(ra + 32'd4, w);
      check(w == 0, "R2", "refetched word hits", 32'(w), 0);

      // R9, R10: invalidate and hitting fetch in the same cycle
      rc = req_count;
      inval_req = 1'b1;
      fork
         begin @(negedge clk); inval_req = 1'b0; end
      join_none
      fetch(ra + 32'd4, w);
      check(w > 256, "R10", "fetch waits through clear", 32'(w), 257);
      check(req_count == rc + 1, "R10", "one new refill after clear", 32'(req_count), 32'(rc + 1));

      // R11: invalidate in the middle of a refill
      repeat (2) @(negedge clk);
      burst_sel = 2'b10; data_delay = 4;
      rc = req_count;
      rf = 32'h000A_BC00;
      fork
         fetch(rf, bg_waits);
      join_none
      repeat (2) @(negedge clk);
      inval_req = 1'b1;
      @(negedge clk);
      inval_req = 1'b0;
      @(negedge clk);
      check(inval_busy, "R11", "busy while refill pending", 32'(inval_busy), 1);
      check(!mem_rvalid, "R11", "refill still in flight", 32'(mem_rvalid), 0);
      wait fork;
      check(bg_waits > 256, "R11", "fetch held across clear", 32'(bg_waits), 257);
      check(req_count == rc + 2, "R11", "refill finished then redone", 32'(req_count), 32'(rc + 2));

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2", "every fetch answered", 32'(exp_q.size()), 0);
      report();
      $finish;
   end

endmodule